// File: doc/BRIEF.md
# Three-Wire Control Register Interface

This block takes configuration commands from a microcontroller over three slow lines: a serial clock, a serial data line and a latch strobe. All three are sampled by the much faster system clock. Each command is a 16-bit word made of a 4-bit register address followed by 12 data bits. When the latch strobe rises, the most recent 16 bits are written into the addressed register.

There are two registers. Register 0 holds five active-low mode flags and a 2-bit frequency select. Each field merges with a hardware pin of the same role, so either the pin or software can assert the function. After reset the register holds the inactive level, which leaves control with the pins. Register 1 holds the channel-status fields that a digital audio transmitter inserts into its frames. The block drives the merged control levels and the status fields as plain outputs. It has no read path.

Top module: `ctl3w_regif`

## Requirements
- R1: After reset, register 0 holds 1 in data bits D6..D2 and 0 in D1..D0, and register 1 holds all zeros. With the pins inactive, every active-low control output is 1, `fsel_o` is 0 and every status output is 0.
- R2: A bit is taken from `ser_dat_i` on each rising edge of `ser_clk_i`. A command is 16 bits sent most significant first: address bits A3..A0, then data bits D11..D0.
- R3: A rising edge on `ser_le_i` writes the last 16 shifted bits into the addressed register. The outputs change within 8 system-clock cycles of that edge.
- R4: In register 0, D6 drives `mute_n_o`, D5 drives `bypass_n_o`, D4 drives `slave_n_o`, D3 drives `txen_n_o`, D2 drives `deemph_n_o`, and D1..D0 drive `fsel_o[1:0]`. Bits D11..D7 have no effect.
- R5: Each active-low control output is 0 when either its pin or its register bit is 0. Each `fsel_o` bit is 1 when either its pin or its register bit is 1.
- R6: In register 1, D11, D10, D9 and D8 drive `cs_ctl_o[0]`, `[1]`, `[2]` and `[3]`. D7 drives `cat_sel_o[0]` and D6 drives `cat_sel_o[1]`. D5 has no effect. D4 drives `cs_lbit_o`. D3 drives `cs_fs_o[0]` and D2 drives `cs_fs_o[1]`. D1 drives `cs_cp_o[0]` and D0 drives `cs_cp_o[1]`.
- R7: A command whose address is 2 through 15 changes no register.
- R8: The bit count restarts at every latch edge. A latch after fewer than 16 new bits writes nothing. After more than 16 bits, only the last 16 are used.
- R9: When the serial clock and the latch strobe rise in the same sampled cycle, the latch wins. The word shifted before that cycle is written, and the clock edge is discarded rather than counted toward the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial command clock |
| ser_dat_i | input | 1 | Serial command data |
| ser_le_i | input | 1 | Latch strobe; the rising edge writes the command |
| pin_mute_n | input | 1 | Mute request pin, active low |
| pin_bypass_n | input | 1 | Bypass request pin, active low |
| pin_slave_n | input | 1 | Slave-timing request pin, active low |
| pin_txen_n | input | 1 | Transmitter enable pin, active low |
| pin_deemph_n | input | 1 | De-emphasis request pin, active low |
| pin_fsel | input | 2 | Frequency select pins |
| mute_n_o | output | 1 | Merged mute level |
| bypass_n_o | output | 1 | Merged bypass level |
| slave_n_o | output | 1 | Merged slave-timing level |
| txen_n_o | output | 1 | Merged transmitter enable level |
| deemph_n_o | output | 1 | Merged de-emphasis level |
| fsel_o | output | 2 | Merged frequency select |
| cs_ctl_o | output | 4 | Channel-status bits 0..3 |
| cat_sel_o | output | 2 | Category code select |
| cs_lbit_o | output | 1 | Channel-status bit 15 |
| cs_fs_o | output | 2 | Channel-status bits 24 and 25 |
| cs_cp_o | output | 2 | Channel-status bits 28 and 29 |

## Verification
Two functions can fall in the same sampled cycle: a serial-clock edge that would shift one more bit, and a latch edge that commits the word. The bench shifts a full command, then raises both lines on the same system-clock step, so they leave the synchronizers together. The check passes only if the outputs show the word from before the coincident edge. A following normal command must then land intact, which shows the discarded edge was not counted. A second overlap, a pin and a register bit asserting the same function, is checked by driving pins against written register values in both directions.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 12;
  localparam int CMD_W    = ADDR_W + DATA_W;
  localparam int NFLAG    = 5;
  localparam int FSEL_W   = 2;
  localparam int MODE_W   = NFLAG + FSEL_W;
  localparam int STAT_W   = DATA_W - 1;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);
  localparam logic [MODE_W-1:0] MODE_RST  = {{NFLAG{1'b1}}, {FSEL_W{1'b0}}};
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              dat_s,
  input  logic              le_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(CMD_W + 1);

  logic             sclk_d, le_d;
  logic             sclk_rise, le_rise;
  logic [CMD_W-1:0] shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign le_rise   = le_s & ~le_d;
  assign full      = (cnt_q == CNT_W'(CMD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      le_d    <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sclk_d <= sclk_s;
      le_d   <= le_s;
      wr_stb <= le_rise & full;
      if (le_rise) begin
        // latch wins over a coincident clock edge; the count restarts
        wr_addr <= shreg_q[CMD_W-1 -: ADDR_W];
        wr_data <= shreg_q[DATA_W-1:0];
        cnt_q   <= '0;
      end else if (sclk_rise) begin
        shreg_q <= {shreg_q[CMD_W-2:0], dat_s};
        if (!full) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NFLAG-1:0]  pin_flag_n,
  input  logic [FSEL_W-1:0] pin_fsel,
  output logic [MODE_W-1:0] r0_q,
  output logic [STAT_W-1:0] r1_q,
  output logic [NFLAG-1:0]  flag_n_o,
  output logic [FSEL_W-1:0] fsel_o,
  output logic [3:0]        cs_ctl_o,
  output logic [1:0]        cat_sel_o,
  output logic              cs_lbit_o,
  output logic [1:0]        cs_fs_o,
  output logic [1:0]        cs_cp_o
);
  logic unused_bits;
  assign unused_bits = ^{wr_data[DATA_W-1:MODE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q <= MODE_RST;
      r1_q <= '0;
    end else if (wr_stb) begin
      case (wr_addr)
        MODE_ADDR: r0_q <= wr_data[MODE_W-1:0];
        STAT_ADDR: r1_q <= {wr_data[11:6], wr_data[4:0]};
        default:   ;
      endcase
    end
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    assign flag_n_o[k] = r0_q[FSEL_W + k] & pin_flag_n[k];
  end
  assign fsel_o = r0_q[FSEL_W-1:0] | pin_fsel;

  // r1_q = {D11,D10,D9,D8,D7,D6,D4,D3,D2,D1,D0}
  assign cs_ctl_o  = {r1_q[7], r1_q[8], r1_q[9], r1_q[10]};
  assign cat_sel_o = {r1_q[5], r1_q[6]};
  assign cs_lbit_o = r1_q[4];
  assign cs_fs_o   = {r1_q[2], r1_q[3]};
  assign cs_cp_o   = {r1_q[0], r1_q[1]};
endmodule

// File: rtl/ctl3w_regif.sv
module ctl3w_regif
  import ctl3w_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       ser_le_i,
  input  logic       pin_mute_n,
  input  logic       pin_bypass_n,
  input  logic       pin_slave_n,
  input  logic       pin_txen_n,
  input  logic       pin_deemph_n,
  input  logic [1:0] pin_fsel,
  output logic       mute_n_o,
  output logic       bypass_n_o,
  output logic       slave_n_o,
  output logic       txen_n_o,
  output logic       deemph_n_o,
  output logic [1:0] fsel_o,
  output logic [3:0] cs_ctl_o,
  output logic [1:0] cat_sel_o,
  output logic       cs_lbit_o,
  output logic [1:0] cs_fs_o,
  output logic [1:0] cs_cp_o
);
  logic [2:0]        ser_s;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [MODE_W-1:0] r0_q;
  logic [STAT_W-1:0] r1_q;
  logic [NFLAG-1:0]  flag_n;

  ctl3w_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_le_i, ser_dat_i, ser_clk_i}),
    .q_o   (ser_s)
  );

  ctl3w_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (ser_s[0]),
    .dat_s   (ser_s[1]),
    .le_s    (ser_s[2]),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  ctl3w_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pin_flag_n ({pin_mute_n, pin_bypass_n, pin_slave_n, pin_txen_n, pin_deemph_n}),
    .pin_fsel   (pin_fsel),
    .r0_q       (r0_q),
    .r1_q       (r1_q),
    .flag_n_o   (flag_n),
    .fsel_o     (fsel_o),
    .cs_ctl_o   (cs_ctl_o),
    .cat_sel_o  (cat_sel_o),
    .cs_lbit_o  (cs_lbit_o),
    .cs_fs_o    (cs_fs_o),
    .cs_cp_o    (cs_cp_o)
  );

  assign {mute_n_o, bypass_n_o, slave_n_o, txen_n_o, deemph_n_o} = flag_n;
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk
  import ctl3w_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [MODE_W-1:0] r0_q,
  input logic [STAT_W-1:0] r1_q,
  input logic              pin_mute_n,
  input logic              mute_n_o,
  input logic [1:0]        pin_fsel,
  input logic [1:0]        fsel_o
);
  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (r0_q == MODE_RST && r1_q == '0));

  // R5
  pin_mute_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_mute_n |-> !mute_n_o);

  // R5
  pin_fsel_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_fsel & ~fsel_o) == 2'b00);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_addr == MODE_ADDR) |=> $stable(r0_q));

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_addr == STAT_ADDR) |=> $stable(r1_q));
endmodule

bind ctl3w_regif ctl3w_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stb     (wr_stb),
  .wr_addr    (wr_addr),
  .r0_q       (r0_q),
  .r1_q       (r1_q),
  .pin_mute_n (pin_mute_n),
  .mute_n_o   (mute_n_o),
  .pin_fsel   (pin_fsel),
  .fsel_o     (fsel_o)
);

// File: tb/ctl3w_regif_bench.sv
module ctl3w_regif_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;
  localparam int NVEC       = 15;

  // {command (sent from bit nbits-1 down), nbits, expected mode view, expected status view}
  // mode view   = {mute_n, bypass_n, slave_n, txen_n, deemph_n, fsel[1:0]}
  // status view = {cs_ctl[3:0], cat_sel[1:0], cs_lbit, cs_fs[1:0], cs_cp[1:0]}
  localparam logic [51:0] VEC [NVEC] = '{
    {24'h000000, 8'd16, 8'h00, 12'h000},
    {24'h000FFF, 8'd16, 8'h7F, 12'h000},
    {24'h000055, 8'd16, 8'h55, 12'h000},
    {24'h001800, 8'd16, 8'h55, 12'h080},
    {24'h0010C0, 8'd16, 8'h55, 12'h060},
    {24'h00101F, 8'd16, 8'h55, 12'h01F},
    {24'h001080, 8'd16, 8'h55, 12'h020},
    {24'h00100A, 8'd16, 8'h55, 12'h005},
    {24'h001400, 8'd16, 8'h55, 12'h100},
    {24'h005FFF, 8'd16, 8'h55, 12'h100},
    {24'h00F000, 8'd16, 8'h55, 12'h100},
    {24'h00007C, 8'd15, 8'h55, 12'h100},
    {24'h00007C, 8'd16, 8'h7C, 12'h100},
    {24'h0F0003, 8'd20, 8'h03, 12'h100},
    {24'h00007C, 8'd16, 8'h7C, 12'h100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic p_mute_n = 1'b1, p_bypass_n = 1'b1, p_slave_n = 1'b1;
  logic p_txen_n = 1'b1, p_deemph_n = 1'b1;
  logic [1:0] p_fsel = 2'b00;
  logic mute_n, bypass_n, slave_n, txen_n, deemph_n, cs_lbit;
  logic [1:0] fsel, cat_sel, cs_fs, cs_cp;
  logic [3:0] cs_ctl;
  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl3w_regif u_ctl3w_regif (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
    .pin_mute_n(p_mute_n), .pin_bypass_n(p_bypass_n), .pin_slave_n(p_slave_n),
    .pin_txen_n(p_txen_n), .pin_deemph_n(p_deemph_n), .pin_fsel(p_fsel),
    .mute_n_o(mute_n), .bypass_n_o(bypass_n), .slave_n_o(slave_n),
    .txen_n_o(txen_n), .deemph_n_o(deemph_n), .fsel_o(fsel),
    .cs_ctl_o(cs_ctl), .cat_sel_o(cat_sel), .cs_lbit_o(cs_lbit),
    .cs_fs_o(cs_fs), .cs_cp_o(cs_cp)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i];
      wait_clks(HOLD);
      ser_clk = 1'b1;
      wait_clks(HOLD);
      ser_clk = 1'b0;
    end
    wait_clks(HOLD);
  endtask

  task automatic pulse_latch();
    ser_le = 1'b1;
    wait_clks(HOLD);
    ser_le = 1'b0;
    wait_clks(HOLD);
  endtask

  task automatic check(input string req, input logic [7:0] exp_mode, input logic [11:0] exp_stat);
    logic [7:0]  got_mode;
    logic [11:0] got_stat;
    got_mode = {1'b0, mute_n, bypass_n, slave_n, txen_n, deemph_n, fsel};
    got_stat = {1'b0, cs_ctl, cat_sel, cs_lbit, cs_fs, cs_cp};
    checks += 2;
    if (got_mode !== exp_mode) begin
      errors++;
      $display("FAIL %s mode: actual %h expected %h", req, got_mode, exp_mode);
    end
    if (got_stat !== exp_stat) begin
      errors++;
      $display("FAIL %s status: actual %h expected %h", req, got_stat, exp_stat);
    end
  endtask

  function automatic string vec_req(input int i);
    if (i < 3)              return "R2/R4";
    if (i < 9)              return "R6";
    if (i < 11)             return "R7";
    if (i == 11 || i == 13) return "R8";
    return "R3";
  endfunction

  initial begin
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(2);
    check("R1 reset", 8'h7C, 12'h000);

    for (int v = 0; v < NVEC; v++) begin
      shift_bits(VEC[v][51:28], int'(VEC[v][27:20]));
      pulse_latch();
      check(vec_req(v), VEC[v][19:12], VEC[v][11:0]);
    end

    // R5: pins assert against an inactive register (reg0 = 7C)
    p_mute_n = 1'b0;
    wait_clks(1);
    check("R5 pin mute", 8'h3C, 12'h100);
    p_mute_n = 1'b1;
    p_fsel = 2'b01;
    wait_clks(1);
    check("R5 pin fsel", 8'h7D, 12'h100);
    p_fsel = 2'b00;
    p_txen_n = 1'b0;
    p_deemph_n = 1'b0;
    wait_clks(1);
    check("R5 pin txen/deemph", 8'h70, 12'h100);
    p_txen_n = 1'b1;
    p_deemph_n = 1'b1;
    // R5: register asserts while pins stay inactive, then a pin adds a frequency bit
    shift_bits(24'h000000, 16);
    pulse_latch();
    check("R5 register only", 8'h00, 12'h100);
    p_fsel = 2'b10;
    wait_clks(1);
    check("R5 fsel or", 8'h02, 12'h100);
    p_fsel = 2'b00;

    // R9: clock edge and latch edge rise together after a full 16-bit word
    shift_bits(24'h000012, 16);
    ser_dat = 1'b1;
    wait_clks(HOLD);
    ser_clk = 1'b1;
    ser_le = 1'b1;
    wait_clks(HOLD);
    ser_clk = 1'b0;
    ser_le = 1'b0;
    wait_clks(2 * HOLD);
    check("R9 coincident latch", 8'h12, 12'h100);
    shift_bits(24'h00007C, 16);
    pulse_latch();
    check("R9 next command", 8'h7C, 12'h100);

    // R1: reset in the middle of a command restores the defaults
    shift_bits(24'h000000, 8);
    rst_n = 1'b0;
    wait_clks(2);
    rst_n = 1'b1;
    wait_clks(2);
    check("R1 reset again", 8'h7C, 12'h000);
    shift_bits(24'h000000, 8);
    pulse_latch();
    check("R8 partial after reset", 8'h7C, 12'h000);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule